// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

The block drives the transmit side of a network controller from a circular list of descriptors that software keeps in system memory. Each descriptor takes two 32-bit words: a control/status word and a byte address of the buffer. Software fills descriptors and marks them as belonging to the hardware. The walker visits them in ring order, streams each buffer out one byte per handshake, writes the completion status back and returns the descriptor to software by clearing the ownership bit.

Fetching starts only on a poll. A poll is either forced by software through the status register or produced by an interval timer. A descriptor still owned by software stops the walk until the next poll. A frame may span several descriptors, bracketed by first and last markers. A descriptor that breaks this bracketing raises a chaining error. Two sticky flags, frame done and chaining error, are each masked by an enable register and ORed into one interrupt line.

Top module: `txring_engine`

## Requirements
- R1: Nothing is fetched from memory unless control register (index 3) bit 0 (global enable) and bit 3 (transmit enable) are both set.
- R2: Writing a 1 to bit 31 of the status register (index 1) requests an immediate poll. A nonzero value N in the poll-rate register (index 4) requests a poll every N cycles. Zero disables timed polls.
- R3: The ring base is written at index 7, with bits 2:0 forced to zero. Descriptor k sits at base+8k, with the control word at +0 and the buffer address at +4. After descriptor RING_DEPTH-1 the walk continues at descriptor 0.
- R4: Control word fields: bit 31 ownership (1 = engine), bit 16 first buffer of frame, bit 17 last buffer, bits 10:0 length in bytes. A descriptor read with bit 31 clear ends the walk until the next poll, and it is left untouched.
- R5: Buffer bytes leave on tx_data in increasing address order, starting at any byte alignment, with lane n of a memory word being bits 8n+7:8n. Each byte is held until tx_ready. tx_last marks only the final byte of a last-marked descriptor.
- R6: The writeback clears bit 31 and keeps bits 17, 16 and 10:0. For a descriptor that closes a frame, frm_stat[0..5] is written to bits 21, 22, 23, 24, 28 and 29. These status bits are zero for any other descriptor.
- R7: A descriptor without the first bit that arrives while no frame is open, or one with the first bit that arrives while a frame is open, is a chaining error. Its buffer is not sent, the open frame is abandoned, the descriptor is written back with zero status, and status bit 3 is set.
- R8: Status bit 0 is set when a frame's last descriptor is written back. Status bits 0 and 3 are cleared by writing 1. irq is high while any status bit is set together with the same bit of the enable register (index 2).
- R9: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte stream valid |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Byte stream sink ready |
| frm_stat | input | 6 | Frame result bits from the transmit line logic |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the walker with RING_DEPTH set to 4 and timed polling generated. Four descriptors are enough to reach the wrap from the last slot back to slot 0 after a handful of frames, and the reused slot 0 is also the one picked up by a timed poll. A poll interval of 60 cycles lets the timer path be observed within a short run. The two-descriptor frame uses unaligned buffers and a toggling tx_ready, so that word refetches and stream stalls fall inside a single frame.

// File: rtl/txring_pkg.sv
package txring_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_INFO,
      S_PTR,
      S_DATA,
      S_EMIT,
      S_WB
   } walk_st_t;

   // register indices decoded by software
   localparam logic [3:0] REG_STATUS = 4'd1;
   localparam logic [3:0] REG_ENABLE = 4'd2;
   localparam logic [3:0] REG_CTRL   = 4'd3;
   localparam logic [3:0] REG_POLL   = 4'd4;
   localparam logic [3:0] REG_BASE   = 4'd7;

   // status / enable / control bits
   localparam int ST_DONE  = 0;
   localparam int ST_CHAIN = 3;
   localparam int ST_KICK  = 31;
   localparam int CT_GLOB  = 0;
   localparam int CT_TXEN  = 3;

   // descriptor control word
   localparam int D_OWN   = 31;
   localparam int D_FIRST = 16;
   localparam int D_LAST  = 17;
   localparam int D_LEN_W = 11;

   // frame result bit positions in the writeback, frm_stat[0..5]
   localparam int D_CARR  = 21;
   localparam int D_DEFER = 22;
   localparam int D_DROP  = 23;
   localparam int D_RETRY = 24;
   localparam int D_LATE  = 28;
   localparam int D_UFLO  = 29;

endpackage

// File: rtl/txring_regs.sv
module txring_regs
   import txring_pkg::*;
#(
   parameter int POLL_W     = 16,
   parameter bit TIMED_POLL = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        frame_done,
   input  logic        chain_err,
   input  logic        poll_take,
   output logic        run,
   output logic        poll_req,
   output logic [31:0] ring_base,
   output logic        irq
);

   logic              done_q, chain_q, pend_q;
   logic              en_done_q, en_chain_q;
   logic              glob_q, txen_q;
   logic [POLL_W-1:0] rate_q;
   logic [28:0]       base_q;
   logic              tick_hit;

   wire wr_stat = reg_we && (reg_addr == REG_STATUS);
   wire kick    = wr_stat && reg_wdata[ST_KICK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q     <= 1'b0;
         chain_q    <= 1'b0;
         pend_q     <= 1'b0;
         en_done_q  <= 1'b0;
         en_chain_q <= 1'b0;
         glob_q     <= 1'b0;
         txen_q     <= 1'b0;
         rate_q     <= '0;
         base_q     <= '0;
      end else begin
         done_q  <= (done_q  & ~(wr_stat & reg_wdata[ST_DONE]))  | frame_done;
         chain_q <= (chain_q & ~(wr_stat & reg_wdata[ST_CHAIN])) | chain_err;
         pend_q  <= (pend_q & ~poll_take) | kick | tick_hit;
         if (reg_we) begin
            case (reg_addr)
               REG_ENABLE: begin
                  en_done_q  <= reg_wdata[ST_DONE];
                  en_chain_q <= reg_wdata[ST_CHAIN];
               end
               REG_CTRL: begin
                  glob_q <= reg_wdata[CT_GLOB];
                  txen_q <= reg_wdata[CT_TXEN];
               end
               REG_POLL: rate_q <= reg_wdata[POLL_W-1:0];
               REG_BASE: base_q <= reg_wdata[31:3];
               default: ;
            endcase
         end
      end
   end

   generate
      if (TIMED_POLL) begin : g_timer
         logic [POLL_W-1:0] tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            tick_q <= '0;
            else if (rate_q == '0 || tick_hit)     tick_q <= '0;
            else                                   tick_q <= tick_q + 1'b1;
         end
         assign tick_hit = (rate_q != '0) && (tick_q == rate_q - 1'b1);
      end else begin : g_no_timer
         assign tick_hit = 1'b0;
      end
   endgenerate

   assign run       = glob_q && txen_q;
   assign poll_req  = pend_q;
   assign ring_base = {base_q, 3'b000};
   assign irq       = (done_q && en_done_q) || (chain_q && en_chain_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_STATUS: begin
            reg_rdata[ST_DONE]  = done_q;
            reg_rdata[ST_CHAIN] = chain_q;
         end
         REG_ENABLE: begin
            reg_rdata[ST_DONE]  = en_done_q;
            reg_rdata[ST_CHAIN] = en_chain_q;
         end
         REG_CTRL: begin
            reg_rdata[CT_GLOB] = glob_q;
            reg_rdata[CT_TXEN] = txen_q;
         end
         REG_POLL: reg_rdata = 32'(rate_q);
         REG_BASE: reg_rdata = ring_base;
         default:  reg_rdata = '0;
      endcase
   end

   AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && reg_wdata[ST_DONE] && !frame_done) |=> !done_q); // R8
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done_q || chain_q)); // R8

endmodule

// File: rtl/txring_walk.sv
module txring_walk
   import txring_pkg::*;
#(
   parameter int RING_DEPTH = 128,
   localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        poll_req,
   input  logic [31:0] ring_base,
   input  logic [5:0]  frm_stat,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        tx_last,
   input  logic        tx_ready,
   output logic        poll_take,
   output logic        frame_done,
   output logic        chain_err
);

   walk_st_t             st_q;
   logic [IDX_W-1:0]     idx_q;
   logic [D_LEN_W-1:0]   len_q, cnt_q;
   logic                 first_q, last_q, chain_q, open_q;
   logic [31:0]          ptr_q, word_q;

   wire [31:0]         desc_addr = ring_base + (32'(idx_q) << 3);
   wire [31:0]         byte_addr = ptr_q + 32'(cnt_q);
   wire [1:0]          lane      = byte_addr[1:0];
   wire [D_LEN_W-1:0]  cnt_nx    = cnt_q + 1'b1;
   wire                ring_end  = (idx_q == IDX_W'(RING_DEPTH - 1));
   wire                rd_first  = mem_rdata[D_FIRST];
   wire                bad_chain = (rd_first && open_q) || (!rd_first && !open_q);
   wire                wb_done   = (st_q == S_WB) && mem_ack;

   always_comb begin
      mem_wdata           = '0;
      mem_wdata[D_FIRST]  = first_q;
      mem_wdata[D_LAST]   = last_q;
      mem_wdata[D_LEN_W-1:0] = len_q;
      if (last_q && !chain_q) begin
         mem_wdata[D_CARR]  = frm_stat[0];
         mem_wdata[D_DEFER] = frm_stat[1];
         mem_wdata[D_DROP]  = frm_stat[2];
         mem_wdata[D_RETRY] = frm_stat[3];
         mem_wdata[D_LATE]  = frm_stat[4];
         mem_wdata[D_UFLO]  = frm_stat[5];
      end
   end

   always_comb begin
      mem_req = (st_q == S_INFO) || (st_q == S_PTR) || (st_q == S_DATA) || (st_q == S_WB);
      mem_we  = (st_q == S_WB);
      case (st_q)
         S_PTR:   mem_addr = desc_addr + 32'd4;
         S_DATA:  mem_addr = {byte_addr[31:2], 2'b00};
         default: mem_addr = desc_addr;
      endcase
   end

   assign tx_valid   = (st_q == S_EMIT);
   assign tx_data    = word_q[{lane, 3'b000} +: 8];
   assign tx_last    = tx_valid && last_q && (cnt_nx == len_q);
   assign poll_take  = (st_q == S_IDLE) && run && poll_req;
   assign frame_done = wb_done && last_q && !chain_q;
   assign chain_err  = wb_done && chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         idx_q   <= '0;
         len_q   <= '0;
         cnt_q   <= '0;
         first_q <= 1'b0;
         last_q  <= 1'b0;
         chain_q <= 1'b0;
         open_q  <= 1'b0;
         ptr_q   <= '0;
         word_q  <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (poll_take) st_q <= S_INFO;
            S_INFO: if (mem_ack) begin
               first_q <= mem_rdata[D_FIRST];
               last_q  <= mem_rdata[D_LAST];
               len_q   <= mem_rdata[D_LEN_W-1:0];
               cnt_q   <= '0;
               chain_q <= bad_chain;
               if (!mem_rdata[D_OWN])  st_q <= S_IDLE;
               else if (bad_chain)     st_q <= S_WB;
               else                    st_q <= S_PTR;
            end
            S_PTR: if (mem_ack) begin
               ptr_q <= mem_rdata;
               st_q  <= (len_q == '0) ? S_WB : S_DATA;
            end
            S_DATA: if (mem_ack) begin
               word_q <= mem_rdata;
               st_q   <= S_EMIT;
            end
            S_EMIT: if (tx_ready) begin
               cnt_q <= cnt_nx;
               if (cnt_nx == len_q)    st_q <= S_WB;
               else if (lane == 2'd3)  st_q <= S_DATA;
            end
            S_WB: if (mem_ack) begin
               idx_q  <= ring_end ? '0 : idx_q + 1'b1;
               open_q <= !(chain_q || last_q);
               st_q   <= run ? S_INFO : S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
   AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !mem_wdata[D_OWN]); // R6
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == S_IDLE) && !run) |=> !mem_req); // R1
   AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      32'(idx_q) < RING_DEPTH); // R3
   AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R5
   AST_NO_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_valid, mem_req})); // R5

endmodule

// File: rtl/txring_engine.sv
module txring_engine
   import txring_pkg::*;
#(
   parameter int RING_DEPTH = 128,
   parameter int MAX_BUF    = 1536,
   parameter int POLL_W     = 16,
   parameter bit TIMED_POLL = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        tx_last,
   input  logic        tx_ready,
   input  logic [5:0]  frm_stat,
   output logic        irq
);

   localparam int LEN_MAX = (1 << D_LEN_W) - 1;

   generate
      if (RING_DEPTH < 2) begin : g_bad_depth
         $error("txring_engine: RING_DEPTH must be at least 2");
      end
      if (MAX_BUF < 1 || MAX_BUF > LEN_MAX) begin : g_bad_buf
         $error("txring_engine: MAX_BUF must fit the length field");
      end
      if (POLL_W < 3 || POLL_W > 32) begin : g_bad_poll
         $error("txring_engine: POLL_W must be within 3..32");
      end
   endgenerate

   logic        run, poll_req, poll_take, frame_done, chain_err;
   logic [31:0] ring_base;

   txring_regs #(
      .POLL_W     (POLL_W),
      .TIMED_POLL (TIMED_POLL)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .frame_done (frame_done),
      .chain_err  (chain_err),
      .poll_take  (poll_take),
      .run        (run),
      .poll_req   (poll_req),
      .ring_base  (ring_base),
      .irq        (irq)
   );

   txring_walk #(
      .RING_DEPTH (RING_DEPTH)
   ) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .poll_req   (poll_req),
      .ring_base  (ring_base),
      .frm_stat   (frm_stat),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .tx_last    (tx_last),
      .tx_ready   (tx_ready),
      .poll_take  (poll_take),
      .frame_done (frame_done),
      .chain_err  (chain_err)
   );

   AST_POLL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      poll_take |-> run); // R1

endmodule

// File: tb/tb_txring_engine.sv
`timescale 1ns/1ps
module tb_txring_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack;
   logic [31:0] mem_rdata;
   logic        tx_valid, tx_last, tx_ready;
   logic [7:0]  tx_data;
   logic [5:0]  fstat = '0;
   logic        irq;
   logic        rdy_slow = 1'b0;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   int req_cnt = 0;
   int ncap = 0;
   logic [7:0]  cap [0:63];
   logic        caplast [0:63];
   logic [31:0] mem [0:1023];
   logic        hw_en = 1'b0;
   logic [31:0] hw_a = '0, hw_d = '0;

   always #4 clk = ~clk;

   assign tx_ready = rdy_slow ? cyc[0] : 1'b1;

   txring_engine #(.RING_DEPTH(4), .MAX_BUF(1536), .POLL_W(16), .TIMED_POLL(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
      .frm_stat(fstat), .irq(irq));

   // memory model: one-cycle acknowledge, host side writes through hw_*
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && !mem_ack && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
         if (mem_req) req_cnt <= req_cnt + 1;
      end
      if (mem_req && mem_ack && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else if (hw_en) mem[hw_a[11:2]] <= hw_d;
      if (tx_valid && tx_ready) begin
         cap[ncap[5:0]]     <= tx_data;
         caplast[ncap[5:0]] <= tx_last;
         ncap <= ncap + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      while (mem_req) @(negedge clk);
      hw_en = 1'b1; hw_a = a; hw_d = d;
      @(negedge clk);
      hw_en = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_release(input logic [31:0] a, input string req);
      int n = 0;
      while (mem[a[11:2]][31] && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(n < 3000, req, mem[a[11:2]], {1'b0, mem[a[11:2]][30:0]});
      repeat (10) @(negedge clk);
   endtask

   task automatic check_bytes(input int start, input logic [7:0] exp [5], input int cnt, input string req);
      chk(ncap - start == cnt, req, 32'(ncap - start), 32'(cnt));
      for (int i = 0; i < cnt; i++) begin
         chk(cap[6'(start + i)] == exp[i], req, {24'd0, cap[6'(start + i)]}, {24'd0, exp[i]});
         chk(caplast[6'(start + i)] == (i == cnt - 1), req,
             {31'd0, caplast[6'(start + i)]}, 32'(i == cnt - 1));
      end
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(4'd1, v);
      chk(v == 32'h0, "R8 reset status", v, 32'h0);
      chk(!irq && !tx_valid && !mem_req, "R1 reset outputs", {29'd0, irq, tx_valid, mem_req}, 32'h0);
   endtask

   task automatic t_disabled;
      int r0;
      for (int k = 0; k < 8; k++) poke(32'h100 + 32'(4 * k), 32'h0);
      wr(4'd7, 32'h0000_0105);                 // R3 low bits dropped
      begin
         logic [31:0] v;
         rd(4'd7, v);
         chk(v == 32'h100, "R3 base alignment", v, 32'h100);
      end
      poke(32'h100, 32'h8003_0005);
      poke(32'h104, 32'h0000_0400);
      poke(32'h400, 32'h4433_2211);
      poke(32'h404, 32'h0000_0055);
      wr(4'd3, 32'h1);                          // global only
      r0 = req_cnt;
      wr(4'd1, 32'h8000_0000);
      repeat (50) @(negedge clk);
      chk(req_cnt == r0, "R1 no fetch without transmit enable", 32'(req_cnt - r0), 32'd0);
      chk(mem[32'h100 >> 2][31], "R1 descriptor untouched", mem[32'h100 >> 2], 32'h8003_0005);
   endtask

   task automatic t_single;
      int s = ncap;
      logic [31:0] v;
      logic [7:0] e [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      fstat = 6'b000001;
      wr(4'd2, 32'h9);
      wr(4'd3, 32'h9);
      wr(4'd1, 32'h8000_0000);                  // R2 forced poll
      wait_release(32'h100, "R2 forced poll");
      check_bytes(s, e, 5, "R5 single descriptor");
      chk(mem[32'h100 >> 2] == 32'h0023_0005, "R6 writeback", mem[32'h100 >> 2], 32'h0023_0005);
      rd(4'd1, v);
      chk(v == 32'h1, "R8 done flag", v, 32'h1);
      chk(irq, "R8 irq", {31'd0, irq}, 32'h1);
   endtask

   task automatic t_chain_two;
      int s;
      logic [31:0] v;
      logic [7:0] e [5] = '{8'hCC, 8'hDD, 8'h44, 8'h99, 8'hAB};
      wr(4'd1, 32'h1);
      rd(4'd1, v);
      chk(v == 32'h0, "R8 write-one-clear", v, 32'h0);
      chk(!irq, "R8 irq drops", {31'd0, irq}, 32'h0);
      poke(32'h500, 32'hDDCC_BBAA);
      poke(32'h504, 32'h1122_3344);
      poke(32'h600, 32'h9988_7766);
      poke(32'h604, 32'h0000_00AB);
      poke(32'h114, 32'h0000_0603);
      poke(32'h110, 32'h8002_0002);
      poke(32'h10C, 32'h0000_0502);
      poke(32'h108, 32'h8001_0003);
      fstat = 6'b100010;
      rdy_slow = 1'b1;
      s = ncap;
      wr(4'd1, 32'h8000_0000);
      wait_release(32'h110, "R4 two descriptors");
      rdy_slow = 1'b0;
      check_bytes(s, e, 5, "R5 unaligned chained frame");
      chk(mem[32'h108 >> 2] == 32'h0001_0003, "R6 non-closing writeback", mem[32'h108 >> 2], 32'h0001_0003);
      chk(mem[32'h110 >> 2] == 32'h2042_0002, "R6 closing writeback", mem[32'h110 >> 2], 32'h2042_0002);
      rd(4'd1, v);
      chk(v == 32'h1, "R8 done after chain", v, 32'h1);
   endtask

   task automatic t_chain_err;
      int s = ncap;
      logic [31:0] v;
      wr(4'd1, 32'h1);
      poke(32'h11C, 32'h0000_0700);
      poke(32'h118, 32'h8000_0004);
      wr(4'd1, 32'h8000_0000);
      wait_release(32'h118, "R7 chain error");
      chk(ncap == s, "R7 buffer not sent", 32'(ncap - s), 32'd0);
      chk(mem[32'h118 >> 2] == 32'h0000_0004, "R7 writeback", mem[32'h118 >> 2], 32'h0000_0004);
      rd(4'd1, v);
      chk(v == 32'h8, "R7 status bit 3", v, 32'h8);
      chk(irq, "R8 chain irq", {31'd0, irq}, 32'h1);
   endtask

   task automatic t_wrap_timed;
      int s = ncap;
      int r0;
      logic [7:0] e [5] = '{8'h5A, 8'h0, 8'h0, 8'h0, 8'h0};
      fstat = 6'b000000;
      poke(32'h800, 32'h0000_005A);
      poke(32'h104, 32'h0000_0800);
      poke(32'h100, 32'h8003_0001);
      wr(4'd4, 32'd60);                          // R2 timed poll
      wait_release(32'h100, "R3 wrap via timed poll");
      check_bytes(s, e, 1, "R3 slot 0 reused");
      chk(mem[32'h100 >> 2] == 32'h0003_0001, "R6 wrap writeback", mem[32'h100 >> 2], 32'h0003_0001);
      wr(4'd4, 32'd0);
      repeat (20) @(negedge clk);
      r0 = req_cnt;
      repeat (100) @(negedge clk);
      chk(req_cnt == r0, "R4 software-owned stops walk", 32'(req_cnt - r0), 32'd0);
      chk(mem[32'h108 >> 2] == 32'h0001_0003, "R4 owned-by-software left alone", mem[32'h108 >> 2], 32'h0001_0003);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_disabled;
      t_single;
      t_chain_two;
      t_chain_err;
      t_wrap_timed;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule